// File: doc/BRIEF.md
# Sixteen-Bit Execute Unit with Sign Flags

This block is the execute stage of a small 16-bit load/store processor that has eight general registers. Each accepted instruction word is decoded for the three arithmetic and logic operations: addition, bitwise AND and bitwise complement. For addition and AND, the second operand comes either from a register or from a sign-extended 5-bit immediate. The block returns the destination register index, the 16-bit result and a write strobe. It also keeps a three-flag sign register (negative, zero, positive), which a later branch stage reads.

The register file lies outside the block. The unit sends out the two source register indices, taken straight from the instruction, and receives the register contents on plain data inputs in the same cycle. Instructions arrive on a valid/ready stream, and results leave on a second valid/ready stream through a one-entry output register. An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, the output holds every field unchanged and no new instruction is taken. Every accepted instruction produces exactly one output beat, including instructions the unit does not execute.

Top module: `alu16_cc_unit`

## Requirements
- R1: Reset is synchronous and active high. Afterwards `out_valid` is 0 and the flags are `cc_flags` = 3'b010, with bit 2 = negative, bit 1 = zero and bit 0 = positive.
- R2: Opcode 4'b0001 (bits 15:12) with bit 5 = 0 writes `src_a_data + src_b_data` modulo 2^16 to the destination given by bits 11:9, with `out_wr` = 1.
- R3: Opcode 4'b0001 with bit 5 = 1 adds the sign-extended value of bits 4:0 instead of `src_b_data`. For example, 16'h14A1 with `src_a_data` = 5 writes 6 to register 2.
- R4: Opcode 4'b0101 writes the bitwise AND of `src_a_data` with either `src_b_data` (bit 5 = 0) or the sign-extended bits 4:0 (bit 5 = 1).
- R5: Opcode 4'b1001 with bits 5:0 = 6'b111111 writes `~src_a_data`. Opcode 4'b1001 with any other bits 5:0 is not executed: `out_wr` = 0 and the flags hold.
- R6: Any other opcode is accepted and yields an output beat with `out_wr` = 0, and it leaves the flags unchanged.
- R7: On every write, the flags are updated on the accepting edge to exactly one set bit: zero if the result is 0, negative if result bit 15 is 1, positive otherwise.
- R8: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_wr`, `out_dest` and `out_result` stay unchanged.
- R9: `src_a_idx` equals instruction bits 8:6 and `src_b_idx` equals bits 2:0, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is valid |
| in_ready | output | 1 | Unit can accept an instruction |
| instr | input | 16 | Instruction word |
| src_a_idx | output | 3 | First source register index to the register file |
| src_b_idx | output | 3 | Second source register index to the register file |
| src_a_data | input | 16 | Contents of the first source register |
| src_b_data | input | 16 | Contents of the second source register |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_wr | output | 1 | Beat carries a register write |
| out_dest | output | 3 | Destination register index |
| out_result | output | 16 | Value to write |
| cc_flags | output | 3 | Sign flags {negative, zero, positive} |

## Verification
The hardest case to reach is a flag update that coincides with back-pressure. One instruction must sit stalled in the output register while the next waits at the input, and the flags must change only when that second instruction is actually accepted. The stimulus first runs directed sequences that hold `out_ready` low for several cycles between writing instructions. It then runs a long random phase with random back-pressure, biased toward operand values that give results of zero, 16'h7FFF, 16'h8000 and 16'hFFFF. A malformed complement and the unexecuted opcodes are placed between writes, to show that the flags hold across them.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_ADD  = 2'd1,
    K_AND  = 2'd2,
    K_NOT  = 2'd3
  } alu_kind_e;
endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int IMM_W  = 5
) (
  input  logic [INSTR_W-1:0] instr,
  output alu_kind_e          kind,
  output logic               use_imm,
  output logic [DATA_W-1:0]  imm_ext,
  output logic [IDX_W-1:0]   dest_idx,
  output logic [IDX_W-1:0]   a_idx,
  output logic [IDX_W-1:0]   b_idx
);
  localparam int OPC_LO  = INSTR_W - OPC_W;
  localparam int DEST_LO = OPC_LO - IDX_W;
  localparam int A_LO    = DEST_LO - IDX_W;
  localparam int MODE_B  = IMM_W;
  localparam int EXT_W   = DATA_W - IMM_W;

  logic [OPC_W-1:0] opc;
  logic [IMM_W:0]   low_bits;

  assign opc      = instr[INSTR_W-1:OPC_LO];
  assign low_bits = instr[MODE_B:0];
  assign use_imm  = instr[MODE_B];
  assign dest_idx = instr[DEST_LO +: IDX_W];
  assign a_idx    = instr[A_LO +: IDX_W];
  assign b_idx    = instr[IDX_W-1:0];
  assign imm_ext  = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};

  always_comb begin
    kind = K_NONE;
    unique case (opc)
      OPC_ADD: kind = K_ADD;
      OPC_AND: kind = K_AND;
      OPC_NOT: kind = (&low_bits) ? K_NOT : K_NONE;
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/alu16_exec.sv
module alu16_exec
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_kind_e         kind,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] imm_ext,
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] b_val,
  output logic              wr,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] opnd_b;

  assign opnd_b = use_imm ? imm_ext : b_val;

  always_comb begin
    wr  = 1'b1;
    res = '0;
    unique case (kind)
      K_ADD:   res = a_val + opnd_b;
      K_AND:   res = a_val & opnd_b;
      K_NOT:   res = ~a_val;
      default: wr  = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] value,
  output logic [2:0]        cc
);
  logic [2:0] next_cc;

  always_comb begin
    if (value == '0)            next_cc = 3'b010;
    else if (value[DATA_W-1])   next_cc = 3'b100;
    else                        next_cc = 3'b001;
  end

  always_ff @(posedge clk) begin
    if (rst)      cc <= 3'b010;
    else if (upd) cc <= next_cc;
  end

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> cc == 3'b010);

  assert_flags_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(cc) == 1);

  assert_flags_follow_R7: assert property (@(posedge clk) disable iff (rst)
    upd |=> (cc[2] == $past(value[DATA_W-1])) && (cc[1] == ($past(value) == '0)));
endmodule

// File: rtl/alu16_cc_unit.sv
module alu16_cc_unit
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int IMM_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] instr,
  output logic [IDX_W-1:0]   src_a_idx,
  output logic [IDX_W-1:0]   src_b_idx,
  input  logic [DATA_W-1:0]  src_a_data,
  input  logic [DATA_W-1:0]  src_b_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_wr,
  output logic [IDX_W-1:0]   out_dest,
  output logic [DATA_W-1:0]  out_result,
  output logic [2:0]         cc_flags
);
  alu_kind_e         kind;
  logic              use_imm;
  logic [DATA_W-1:0] imm_ext;
  logic [IDX_W-1:0]  dest_idx;
  logic              exec_wr;
  logic [DATA_W-1:0] exec_res;
  logic              fire;

  alu16_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W), .IMM_W(IMM_W)) u_dec (
    .instr(instr), .kind(kind), .use_imm(use_imm), .imm_ext(imm_ext),
    .dest_idx(dest_idx), .a_idx(src_a_idx), .b_idx(src_b_idx)
  );

  alu16_exec #(.DATA_W(DATA_W)) u_exec (
    .kind(kind), .use_imm(use_imm), .imm_ext(imm_ext),
    .a_val(src_a_data), .b_val(src_b_data), .wr(exec_wr), .res(exec_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  alu16_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .upd(fire && exec_wr), .value(exec_res), .cc(cc_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_wr     <= 1'b0;
      out_dest   <= '0;
      out_result <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_wr     <= exec_wr;
      out_dest   <= dest_idx;
      out_result <= exec_res;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_wr) &&
                                   $stable(out_dest) && $stable(out_result)));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(fire && exec_wr) |=> $stable(cc_flags));

  assert_not_result_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && instr[INSTR_W-1 -: OPC_W] == OPC_NOT && (&instr[IMM_W:0]))
      |=> (out_wr && out_result == ~$past(src_a_data)));

  assert_dest_field_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && exec_wr) |=> (out_dest == $past(instr[11:9])));
endmodule

// File: tb/alu16_cc_unit_test.sv
module alu16_cc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] instr = '0;
  logic [2:0]  src_a_idx, src_b_idx;
  logic [15:0] src_a_data = '0, src_b_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_wr;
  logic [2:0]  out_dest;
  logic [15:0] out_result;
  logic [2:0]  cc_flags;

  always #10 clk = ~clk;

  alu16_cc_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .instr(instr),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .src_a_data(src_a_data), .src_b_data(src_b_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_wr(out_wr),
    .out_dest(out_dest), .out_result(out_result), .cc_flags(cc_flags)
  );

  int total = 0;
  int bad   = 0;

  bit          m_valid = 0;
  bit          m_wr    = 0;
  logic [2:0]  m_dest  = '0;
  logic [15:0] m_res   = '0;
  logic [2:0]  m_cc    = 3'b010;
  string       m_tag   = "R1";

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(out_valid === m_valid, m_tag, "out_valid", 32'(out_valid), 32'(m_valid));
    if (m_valid) begin
      check(out_wr === m_wr, m_tag, "out_wr", 32'(out_wr), 32'(m_wr));
      if (m_wr) begin
        check(out_dest === m_dest, m_tag, "out_dest", 32'(out_dest), 32'(m_dest));
        check(out_result === m_res, m_tag, "out_result", 32'(out_result), 32'(m_res));
      end
    end
    check(cc_flags === m_cc, (m_tag == "R1") ? "R1" : "R7", "cc_flags",
          32'(cc_flags), 32'(m_cc));
  endtask

  task automatic step(input bit v, input logic [15:0] ins, input logic [15:0] a,
                      input logic [15:0] b, input bit rdy);
    bit          fire;
    logic [15:0] imm, opb, r;
    bit          w;
    string       t;
    @(negedge clk);
    compare();
    in_valid = v; instr = ins; src_a_data = a; src_b_data = b; out_ready = rdy;
    #1;
    check(in_ready === (!m_valid || rdy), "R8", "in_ready", 32'(in_ready),
          32'(!m_valid || rdy));
    check(src_a_idx === ins[8:6], "R9", "src_a_idx", 32'(src_a_idx), 32'(ins[8:6]));
    check(src_b_idx === ins[2:0], "R9", "src_b_idx", 32'(src_b_idx), 32'(ins[2:0]));
    fire = v && (!m_valid || rdy);
    if (fire) begin
      imm = {{11{ins[4]}}, ins[4:0]};
      opb = ins[5] ? imm : b;
      w = 1; r = '0;
      case (ins[15:12])
        4'h1: begin r = a + opb; t = ins[5] ? "R3" : "R2"; end
        4'h5: begin r = a & opb; t = "R4"; end
        4'h9: begin
          t = "R5";
          if (ins[5:0] == 6'h3F) r = ~a; else w = 0;
        end
        default: begin w = 0; t = "R6"; end
      endcase
      m_valid = 1; m_wr = w; m_dest = ins[11:9]; m_res = r; m_tag = t;
      if (w) m_cc = (r == 0) ? 3'b010 : (r[15] ? 3'b100 : 3'b001);
    end else if (m_valid && rdy) begin
      m_valid = 0;
    end
  endtask

  function automatic logic [15:0] mk(input logic [3:0] op, input logic [2:0] dr,
                                     input logic [2:0] s1, input logic md,
                                     input logic [4:0] lo);
    return {op, dr, s1, md, lo};
  endfunction

  function automatic logic [15:0] pick_val();
    int k = $urandom_range(0, 7);
    case (k)
      0: return 16'h0000;
      1: return 16'h7FFF;
      2: return 16'h8000;
      3: return 16'hFFFF;
      4: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid in reset", 32'(out_valid), 0);
    rst = 1'b0;
    step(0, 16'h0, 0, 0, 1);
    // R3: the worked example word
    step(1, 16'h14A1, 16'd5, 16'd99, 1);
    // R2: overflow into the sign bit gives negative flags
    step(1, mk(4'h1, 3'd1, 3'd3, 1'b0, 5'b00100), 16'h7FFF, 16'h0001, 1);
    // R3: most negative immediate gives zero
    step(1, mk(4'h1, 3'd4, 3'd5, 1'b1, 5'b10000), 16'd16, 16'hAAAA, 1);
    // R4: register and immediate forms
    step(1, mk(4'h5, 3'd6, 3'd0, 1'b0, 5'b00111), 16'hF0F0, 16'h0F0F, 1);
    step(1, mk(4'h5, 3'd7, 3'd2, 1'b1, 5'b11111), 16'h8001, 16'h0000, 1);
    // R5: complement, then malformed complement holds flags
    step(1, mk(4'h9, 3'd3, 3'd1, 1'b1, 5'b11111), 16'h0000, 16'h1234, 1);
    step(1, mk(4'h9, 3'd3, 3'd1, 1'b1, 5'b11110), 16'h1234, 16'h1234, 1);
    step(1, mk(4'h9, 3'd2, 3'd1, 1'b1, 5'b11111), 16'hFFFF, 16'h0, 1);
    step(1, mk(4'h9, 3'd2, 3'd1, 1'b0, 5'b11111), 16'hFFFF, 16'h0, 1);
    // R6: unexecuted opcodes
    step(1, 16'h0FFF, 16'h8000, 16'h8000, 1);
    step(1, 16'hE123, 16'h8000, 16'h8000, 1);
    step(1, 16'hF025, 16'h8000, 16'h8000, 1);
    // R8: stall with a second writer waiting
    step(1, mk(4'h1, 3'd5, 3'd5, 1'b1, 5'b00001), 16'h0010, 16'h0, 0);
    step(1, mk(4'h1, 3'd6, 3'd5, 1'b1, 5'b11111), 16'h0001, 16'h0, 0);
    step(1, mk(4'h1, 3'd6, 3'd5, 1'b1, 5'b11111), 16'h0001, 16'h0, 0);
    step(1, mk(4'h1, 3'd6, 3'd5, 1'b1, 5'b11111), 16'h0001, 16'h0, 1);
    step(0, 16'h0, 16'h0, 16'h0, 1);
    step(0, 16'h0, 16'h0, 16'h0, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] op;
      int sel = $urandom_range(0, 9);
      if (sel < 3) op = 4'h1;
      else if (sel < 5) op = 4'h5;
      else if (sel < 8) op = 4'h9;
      else op = 4'($urandom);
      step($urandom_range(0, 3) != 0,
           (op == 4'h9 && $urandom_range(0, 2) != 0) ?
             {op, 3'($urandom), 3'($urandom), 6'h3F} : {op, 12'($urandom)},
           pick_val(), pick_val(), $urandom_range(0, 2) != 0);
    end
    step(0, 16'h0, 0, 0, 1);
    step(0, 16'h0, 0, 0, 1);
    @(negedge clk);
    compare();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule